// File: doc/BRIEF.md
# Shadowed Memory Store/Recall Engine

This block is a byte-wide volatile memory paired with a nonvolatile shadow array of the same size, and a sequencer that moves data between the two. A host reads and writes the volatile array through a simple synchronous port. A store pulse copies the whole volatile array into the shadow. A recall pulse copies the shadow back into the volatile array.

A store runs in two phases. First the shadow is erased: every byte becomes 0xFF, and the erase phase lasts a set number of cycles. Then every shadow byte is programmed from the volatile array. A recall is a single copy phase. Both copy phases walk the addresses in order, one byte per clock. While an operation runs, the block raises `busy` and locks the host out: reads return zero, writes are dropped, and new triggers are ignored. Erase and program time are counted in clock cycles.

Depth is 2^`ADDR_W` locations. Setting `ADDR_W` to 15 gives the 32K x 8 organisation. The default is kept smaller so that elaboration stays light.

The sequencer has four states:
- `ST_IDLE`: host access is open.
- `ST_ERASE`: the shadow is cleared on the first cycle, and the state holds for `ERASE_CYC` cycles.
- `ST_PROG`: one shadow byte is written per cycle.
- `ST_RECALL`: one volatile byte is written per cycle.

Its transitions are:
- idle to erase on `store_go`.
- idle to recall on `recall_go` when `store_go` is low.
- erase to program after the last erase cycle.
- program to idle after address DEPTH-1.
- recall to idle after address DEPTH-1.

Top module: `shadow_store_recall`

## Requirements
- R1: After reset, `busy` is 0 and `host_rdata` is 0.
- R2: While `busy` is 0, a write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`. A read (`host_en`=1, `host_we`=0) returns the stored byte on `host_rdata` one clock later.
- R3: A `store_go` pulse while idle raises `busy` from the next clock. `busy` stays high for exactly `ERASE_CYC` + DEPTH cycles.
- R4: After a store, the shadow holds the volatile contents captured at the store. A later recall makes this visible.
- R5: A `recall_go` pulse while idle holds `busy` high for exactly DEPTH cycles. Afterwards every volatile byte equals the corresponding shadow byte.
- R6: In the cycle after any cycle with `busy`=1, `host_rdata` is 0, even when a read was requested.
- R7: Host writes issued while `busy`=1 change neither the volatile array nor the shadow.
- R8: `store_go` or `recall_go` raised while `busy`=1 is ignored. The running operation keeps its length, and no second operation follows. `busy` rises only after a trigger.
- R9: If `store_go` and `recall_go` arrive in the same idle cycle, the store runs and the recall is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data, 0 when no read is served |
| store_go | input | 1 | Start an erase-then-program store |
| recall_go | input | 1 | Start a shadow-to-volatile recall |
| busy | output | 1 | Operation in progress, host locked out |

## Verification
The copy paths are tested with an address-dependent pattern, then its complement, then a third distinct pattern. A recall therefore returns only the data captured at the last store, and a stale or partial copy cannot match by chance. Busy windows are counted in cycles, which separates a store (erase plus program) from a recall and catches off-by-one ends. The same pattern checks also show whether an operation was restarted or added. Lockout is tested by hammering one address with writes, reads and the opposite trigger during both kinds of operation. A follow-up recall then shows whether the dropped write or the dropped trigger reached either array.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_PROG   = 2'd2,
        ST_RECALL = 2'd3
    } eng_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/shadow_vol_ram.sv
module shadow_vol_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/shadow_nv_array.sv
module shadow_nv_array
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Bulk erase clears every cell at once; programming is byte by byte.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(ERASED_BYTE);
            end
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/shadow_copy_fsm.sv
module shadow_copy_fsm
    import shadow_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int ERASE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_go,
    input  logic              recall_go,
    output logic              busy,
    output logic              erase_pulse,
    output logic              nv_we,
    output logic              vol_we,
    output logic [ADDR_W-1:0] xfer_addr
);
    localparam int CNT_W = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;
    localparam logic [CNT_W-1:0]  ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST  = {ADDR_W{1'b1}};

    eng_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (store_go) begin
                    state_d = ST_ERASE;
                end else if (recall_go) begin
                    state_d = ST_RECALL;
                end
            end
            ST_ERASE: begin
                if (cnt_q == ERASE_LAST) begin
                    state_d = ST_PROG;
                end
            end
            ST_PROG: begin
                if (addr_q == ADDR_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RECALL: begin
                if (addr_q == ADDR_LAST) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register with its phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_ERASE) ? cnt_q + 1'b1 : '0;
            addr_q  <= (state_q == ST_PROG || state_q == ST_RECALL)
                       ? addr_q + 1'b1 : '0;
        end
    end

    // Outputs
    always_comb begin
        busy        = 1'b1;
        erase_pulse = 1'b0;
        nv_we       = 1'b0;
        vol_we      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy        = 1'b0;
            ST_ERASE:  erase_pulse = (cnt_q == '0);
            ST_PROG:   nv_we       = 1'b1;
            ST_RECALL: vol_we      = 1'b1;
        endcase
    end

    assign xfer_addr = addr_q;

endmodule

// File: rtl/shadow_store_recall.sv
module shadow_store_recall #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              store_go,
    input  logic              recall_go,
    output logic              busy
);
    logic              eng_busy;
    logic              erase_pulse;
    logic              nv_we;
    logic              eng_vol_we;
    logic [ADDR_W-1:0] xfer_addr;

    logic              vol_we;
    logic [ADDR_W-1:0] vol_addr;
    logic [DATA_W-1:0] vol_wdata;
    logic [DATA_W-1:0] vol_rdata;
    logic [DATA_W-1:0] nv_rdata;
    logic [DATA_W-1:0] rdata_q;
    logic              host_rd;

    shadow_copy_fsm #(
        .ADDR_W    (ADDR_W),
        .ERASE_CYC (ERASE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_go    (store_go),
        .recall_go   (recall_go),
        .busy        (eng_busy),
        .erase_pulse (erase_pulse),
        .nv_we       (nv_we),
        .vol_we      (eng_vol_we),
        .xfer_addr   (xfer_addr)
    );

    // The host owns the volatile port only while the engine is idle.
    always_comb begin
        if (eng_busy) begin
            vol_we    = eng_vol_we;
            vol_addr  = xfer_addr;
            vol_wdata = nv_rdata;
        end else begin
            vol_we    = host_en & host_we;
            vol_addr  = host_addr;
            vol_wdata = host_wdata;
        end
    end

    shadow_vol_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_vol (
        .clk   (clk),
        .we    (vol_we),
        .addr  (vol_addr),
        .wdata (vol_wdata),
        .rdata (vol_rdata)
    );

    shadow_nv_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_nv (
        .clk   (clk),
        .erase (erase_pulse),
        .we    (nv_we),
        .addr  (xfer_addr),
        .wdata (vol_rdata),
        .rdata (nv_rdata)
    );

    assign host_rd = host_en & ~host_we & ~eng_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= host_rd ? vol_rdata : '0;
        end
    end

    assign host_rdata = rdata_q;
    assign busy       = eng_busy;

endmodule

// File: rtl/shadow_store_recall_chk.sv
module shadow_store_recall_chk #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              store_go,
    input logic              recall_go,
    input logic              busy,
    input logic [DATA_W-1:0] host_rdata
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int STORE_LEN  = ERASE_CYC + DEPTH;
    localparam int RECALL_LEN = DEPTH;

    int   run_len;
    logic was_store;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len   <= 0;
            was_store <= 1'b0;
        end else begin
            run_len <= busy ? run_len + 1 : 0;
            if (!busy && (store_go || recall_go)) begin
                was_store <= store_go;
            end
        end
    end

    // R3
    store_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && was_store) |-> (run_len == STORE_LEN));

    // R5
    recall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !was_store) |-> (run_len == RECALL_LEN));

    // R6
    rdata_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (host_rdata == '0));

    // R8
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(store_go || recall_go));

endmodule

bind shadow_store_recall shadow_store_recall_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_go   (store_go),
    .recall_go  (recall_go),
    .busy       (busy),
    .host_rdata (host_rdata)
);

// File: tb/sim_shadow_store_recall.sv
module sim_shadow_store_recall;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int ERASE_CYC = 6;
    localparam int DEPTH     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_en = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              store_go = 1'b0;
    logic              recall_go = 1'b0;
    logic              busy;

    int applied = 0;
    int errors  = 0;

    logic [DATA_W-1:0] vol_m [DEPTH];
    logic [DATA_W-1:0] shd_m [DEPTH];

    always #2 clk = ~clk;

    shadow_store_recall #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ERASE_CYC (ERASE_CYC)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_en    (host_en),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .store_go   (store_go),
        .recall_go  (recall_go),
        .busy       (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input int d);
        host_en = 1'b1; host_we = 1'b1;
        host_addr = ADDR_W'(a); host_wdata = DATA_W'(d);
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output int d);
        host_en = 1'b1; host_we = 1'b0; host_addr = ADDR_W'(a);
        @(negedge clk);
        d = int'(host_rdata);
        host_en = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < DEPTH; i++) begin
            vol_m[i] = DATA_W'(i * seed + 8'h3C);
            host_write(i, int'(vol_m[i]));
        end
    endtask

    task automatic verify_vol(input string req);
        int d;
        for (int i = 0; i < DEPTH; i++) begin
            host_read(i, d);
            chk(req, d, int'(vol_m[i]));
        end
    endtask

    // Runs one operation; optionally pokes the host port and the other trigger.
    task automatic run_op(input bit do_store, input bit both, input bit poke,
                          input string req_len, input int exp_len);
        int n = 0;
        store_go = do_store; recall_go = both | ~do_store;
        @(negedge clk);
        store_go = 1'b0; recall_go = 1'b0;
        while (busy && n < 4000) begin
            if (poke) begin
                if (n > 0) chk("R6", int'(host_rdata), 0);
                host_en = 1'b1; host_we = n[0];
                host_addr = ADDR_W'(5); host_wdata = 8'h5A;
                if (do_store) recall_go = 1'b1; else store_go = 1'b1;
            end
            @(negedge clk);
            n++;
        end
        host_en = 1'b0; host_we = 1'b0; store_go = 1'b0; recall_go = 1'b0;
        chk(req_len, n, exp_len);
        @(negedge clk);
        chk("R8", int'(busy), 0);
        if (do_store) begin
            for (int i = 0; i < DEPTH; i++) shd_m[i] = vol_m[i];
        end else begin
            for (int i = 0; i < DEPTH; i++) vol_m[i] = shd_m[i];
        end
    endtask

    task automatic t_reset;
        chk("R1", int'(busy), 0);
        chk("R1", int'(host_rdata), 0);
    endtask

    task automatic t_host_rw;
        fill(17);
        verify_vol("R2");
        host_write(DEPTH - 1, 8'hE7); vol_m[DEPTH-1] = 8'hE7;
        host_write(0, 8'h00); vol_m[0] = 8'h00;
        verify_vol("R2");
    endtask

    task automatic t_store_recall;
        run_op(1'b1, 1'b0, 1'b0, "R3", ERASE_CYC + DEPTH);
        fill(~29);
        verify_vol("R2");
        run_op(1'b0, 1'b0, 1'b0, "R5", DEPTH);
        verify_vol("R4");
    endtask

    task automatic t_lock_store;
        fill(41);
        run_op(1'b1, 1'b0, 1'b1, "R8", ERASE_CYC + DEPTH);
        verify_vol("R7");
        fill(7);
        run_op(1'b0, 1'b0, 1'b0, "R5", DEPTH);
        verify_vol("R7");
    endtask

    task automatic t_lock_recall;
        fill(93);
        run_op(1'b0, 1'b0, 1'b1, "R8", DEPTH);
        verify_vol("R5");
        fill(11);
        run_op(1'b0, 1'b0, 1'b0, "R5", DEPTH);
        verify_vol("R8");
    endtask

    task automatic t_both;
        fill(55);
        run_op(1'b1, 1'b1, 1'b0, "R9", ERASE_CYC + DEPTH);
        verify_vol("R9");
        fill(3);
        run_op(1'b0, 1'b0, 1'b0, "R5", DEPTH);
        verify_vol("R9");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_rw();
        t_store_recall();
        t_lock_store();
        t_lock_recall();
        t_both();
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule